// File: doc/BRIEF.md
# Power-Mode and Clock-Divider Controller

This block is the power control register of a small microcontroller, together with the logic that enforces it. Software writes a 12-bit word that carries a 3-bit core clock divider code and enable bits for the CPU core, the peripheral group, the PLL and the precision oscillator. The register drives one power-enable output per domain. It also emits a single-cycle clock-enable strobe that divides the master clock by a power of two.

The domains power down in a fixed order: the core first, then the peripherals, then the PLL. A write that would turn off a domain while a domain that depends on it stays on is refused for that bit. A wake-up pulse turns the core, peripheral and PLL enables back on without any software action. The oscillator bit and the divider code are left as they are on a wake-up.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: With divider code N in bits 2:0, `clk_en_o` is high for one master cycle out of every 2^N master cycles. Code 0 gives a strobe every cycle and code 7 gives one every 128 cycles.
- R2: After reset the register reads 0x039. That is divider code 1, and core (bit 3), peripheral (bit 4) and PLL (bit 5) enabled, with the oscillator (bit 8) off.
- R3: A write sets or clears the core-enable bit 3 directly. `core_en_o` follows the bit.
- R4: A wake-up pulse sets bits 3, 4 and 5 to 1 on the next clock edge.
- R5: A write that clears bit 4 leaves bit 4 unchanged unless the same write also clears bit 3.
- R6: A write that clears bit 5 leaves bit 5 unchanged unless the same write also clears bits 3 and 4.
- R7: The oscillator-enable bit 8 changes only by software write. A wake-up pulse does not change it.
- R8: Bits 11:9 and 7:6 always read as 0, whatever was written to them.
- R9: A new divider code takes effect only after the strobe that ends the current period. The period that is running at the time of the write keeps its old length.
- R10: When a wake-up pulse and a write arrive in the same cycle, bits 3, 4 and 5 become 1. Bits 2:0 and bit 8 take the written values.
- R11: While the PLL-enable bit is 0, `clk_en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 12 | Register write data |
| wake_i | input | 1 | Wake-up event pulse |
| rd_data_o | output | 12 | Register read data |
| core_en_o | output | 1 | Core power enable |
| periph_en_o | output | 1 | Peripheral group power enable |
| pll_en_o | output | 1 | PLL power enable |
| osc_en_o | output | 1 | Precision oscillator enable |
| clk_en_o | output | 1 | Divided core clock-enable strobe |

## Verification
The hardest case to reach is a divider change that lands exactly on a strobe boundary. The result is only visible in the lengths of the two periods that follow it. The stimulus first waits at a falling edge until it sees a strobe. It then writes the new code in that same half cycle, so the write lands on the edge that closes the period. It then measures the remainder of the old period, which should be 3 more cycles for code 2. After that it measures one full period at the new length. A second case that is hard to reach is a wake-up pulse that coincides with a write of all-off bits. The bench drives both inputs in the same cycle.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;
  localparam int unsigned REG_W   = 12;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned CORE_B  = 3;
  localparam int unsigned PERI_B  = 4;
  localparam int unsigned PLL_B   = 5;
  localparam int unsigned OSC_B   = 8;
  localparam logic [DIV_W-1:0] DIV_RST = 3'd1;

  typedef struct packed {
    logic             osc;
    logic             pll;
    logic             peri;
    logic             core;
    logic [DIV_W-1:0] div;
  } pwr_state_t;
endpackage

// File: rtl/pwr_reg.sv
module pwr_reg
  import pwr_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             wake_i,
  output pwr_state_t       state_o
);
  pwr_state_t st_q, st_d;
  logic w_core, w_peri, w_pll;

  assign w_core = wr_data_i[CORE_B];
  assign w_peri = wr_data_i[PERI_B];
  assign w_pll  = wr_data_i[PLL_B];

  always_comb begin
    st_d = st_q;
    if (wr_en_i) begin
      st_d.div  = wr_data_i[DIV_W-1:0];
      st_d.osc  = wr_data_i[OSC_B];
      st_d.core = w_core;
      // clears refused unless higher domains go down in the same write
      st_d.peri = w_peri | (w_core ? st_q.peri : 1'b0);
      st_d.pll  = w_pll | ((w_core | w_peri) ? st_q.pll : 1'b0);
    end
    if (wake_i) begin
      st_d.core = 1'b1;
      st_d.peri = 1'b1;
      st_d.pll  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.div  <= DIV_RST;
      st_q.core <= 1'b1;
      st_q.peri <= 1'b1;
      st_q.pll  <= 1'b1;
      st_q.osc  <= 1'b0;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

  AST_WAKE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (st_q.core && st_q.peri && st_q.pll)); // R4
  AST_PERI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && w_core && !wake_i) |=> (st_q.peri == $past(st_q.peri | w_peri))); // R5
  AST_PLL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (w_core || w_peri) && !wake_i) |=> (st_q.pll == $past(st_q.pll | w_pll))); // R6
  AST_OSC_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(st_q.osc)); // R7
endmodule

// File: rtl/clk_div_stb.sv
module clk_div_stb #(
  parameter int unsigned DIV_W = 3,
  localparam int unsigned CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             stb_o
);
  logic [DIV_W-1:0] act_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic [CNT_W:0]   one_sh;
  logic             hit;

  assign one_sh = (CNT_W+1)'(1) << act_q;
  assign lim    = CNT_W'(one_sh - 1'b1);
  assign hit    = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= DIV_W'(1);
    end else if (!en_i) begin
      cnt_q <= '0;
      act_q <= code_i;
    end else if (hit) begin
      // period boundary: load pending code
      cnt_q <= '0;
      act_q <= code_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stb_o = en_i & hit;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim); // R1
  AST_CODE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hit) |=> $stable(act_q)); // R9
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [11:0] wr_data_i,
  input  logic        wake_i,
  output logic [11:0] rd_data_o,
  output logic        core_en_o,
  output logic        periph_en_o,
  output logic        pll_en_o,
  output logic        osc_en_o,
  output logic        clk_en_o
);
  pwr_state_t st;

  pwr_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wake_i    (wake_i),
    .state_o   (st)
  );

  clk_div_stb #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st.pll),
    .code_i (st.div),
    .stb_o  (clk_en_o)
  );

  always_comb begin
    rd_data_o               = '0;
    rd_data_o[DIV_W-1:0]    = st.div;
    rd_data_o[CORE_B]       = st.core;
    rd_data_o[PERI_B]       = st.peri;
    rd_data_o[PLL_B]        = st.pll;
    rd_data_o[OSC_B]        = st.osc;
  end

  assign core_en_o   = st.core;
  assign periph_en_o = st.peri;
  assign pll_en_o    = st.pll;
  assign osc_en_o    = st.osc;

  AST_NO_STROBE_PLL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_o |-> !clk_en_o); // R11
  AST_HIERARCHY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wake_i && wr_data_i[CORE_B]) |=> ($past(periph_en_o) -> periph_en_o)); // R5
endmodule

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic        wake = 1'b0;
  logic [11:0] rd_data;
  logic        core_en, peri_en, pll_en, osc_en, clk_en;

  int n_chk = 0;
  int n_bad = 0;
  logic chk_req = 1'b0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pwr_clk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wake_i(wake), .rd_data_o(rd_data), .core_en_o(core_en),
    .periph_en_o(peri_en), .pll_en_o(pll_en), .osc_en_o(osc_en),
    .clk_en_o(clk_en)
  );

  // monitor: pops expected register image and compares
  always @(negedge clk) begin
    if (chk_req && exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data !== e || core_en !== e[3] || peri_en !== e[4] ||
          pll_en !== e[5] || osc_en !== e[8]) begin
        n_bad++;
        $display("FAIL %s: rd=%h exp=%h", t, rd_data, e);
      end
    end
  end

  task automatic expect_reg(input logic [11:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    chk_req <= 1'b1;
    @(negedge clk);
    chk_req <= 1'b0;
  endtask

  task automatic check_int(input int act, input int expv, input string t);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got=%0d exp=%0d", t, act, expv);
    end
  endtask

  task automatic wr(input logic [11:0] d, input logic wk);
    wr_en = 1'b1; wr_data = d; wake = wk;
    @(negedge clk);
    wr_en = 1'b0; wake = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic sync_stb();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (clk_en) break;
    end
  endtask

  task automatic get_gap(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (clk_en) break;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got=timeout exp=done");
    finish_run();
  end

  initial begin
    int g, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg(12'h039, "R2 reset image");
    sync_stb(); get_gap(g); check_int(g, 2, "R1 reset code 1 gap");

    wr(12'hFFF, 1'b0);
    expect_reg(12'h13F, "R8 reserved read zero");
    wr(12'h137, 1'b0);
    expect_reg(12'h137, "R3 core clear");
    wr(12'h12F, 1'b0);
    expect_reg(12'h13F, "R5 periph clear refused");
    wr(12'h127, 1'b0);
    expect_reg(12'h127, "R5 periph clear accepted");
    wr(12'h10F, 1'b0);
    expect_reg(12'h12F, "R6 pll clear refused");
    wr(12'h107, 1'b0);
    expect_reg(12'h107, "R6 pll clear accepted");
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (clk_en) cnt++;
    end
    check_int(cnt, 0, "R11 no strobe with pll off");
    pulse_wake();
    expect_reg(12'h13F, "R4 R7 wake restores, osc kept");

    wr(12'h007, 1'b0);
    expect_reg(12'h007, "R7 osc cleared by write");
    wr(12'h102, 1'b1);
    expect_reg(12'h13A, "R10 wake plus write");

    wr(12'h03A, 1'b0);
    sync_stb(); get_gap(g); check_int(g, 4, "R1 code 2 gap");
    wr(12'h038, 1'b0);
    sync_stb(); get_gap(g); check_int(g, 1, "R1 code 0 gap");
    wr(12'h03F, 1'b0);
    sync_stb(); get_gap(g); check_int(g, 128, "R1 code 7 gap");

    wr(12'h03A, 1'b0);
    sync_stb(); sync_stb();
    wr(12'h03D, 1'b0);
    get_gap(g); check_int(g, 3, "R9 old period kept");
    get_gap(g); check_int(g, 32, "R9 new period after boundary");

    finish_run();
  end
endmodule